// File: doc/BRIEF.md
# Second-Operand Rotate and Shift Unit

This combinational unit builds the second ALU operand from the low twelve bits of a data-processing instruction word. It has two modes, picked by a single select input. In immediate mode, an 8-bit constant is widened to 32 bits and rotated right by an even distance. In register mode, a 32-bit value that has already been read from the register file is shifted or rotated by a 5-bit constant distance. The unit also produces a shifter carry that the flag logic can use when an instruction updates the status bits.

The register file is read outside this unit. The unit passes the 4-bit source index from the field to the register file and takes the value that comes back on `reg_val`. Shifting changes only that value in flight and never the stored register. If register mode asks for a register-specified shift distance (field bit 4 set), the unit does not handle that encoding. It raises `illegal` and passes the value through unshifted.

Top module: `operand_shifter_unit`

## Requirements
- R1: In immediate mode (`imm_sel`=1), `operand` equals field bits 7:0, zero-extended to 32 bits and rotated right by 2 × field bits 11:8 (unsigned). A rotate right by one moves bit i to bit i−1 and moves bit 0 to bit 31.
- R2: In immediate mode, `carry_out` equals `carry_in` when field bits 11:8 are zero. Otherwise it equals bit 31 of `operand`.
- R3: In register mode (`imm_sel`=0, field bit 4 = 0), shift code 00 in field bits 6:5 shifts `reg_val` left by the distance in field bits 11:7 and fills the low bits with zeros.
- R4: Shift code 01 shifts `reg_val` right logically and fills the high bits with zeros.
- R5: Shift code 10 shifts `reg_val` right arithmetically and fills the high bits with the original bit 31.
- R6: Shift code 11 rotates `reg_val` right by the distance.
- R7: In register mode with a nonzero distance, `carry_out` is the last bit moved out. For a left shift by n this is `reg_val`[32−n]. For the three right-going codes it is `reg_val`[n−1].
- R8: In register mode with distance 0, `operand` equals `reg_val` and `carry_out` equals `carry_in`, for every shift code.
- R9: In register mode with field bit 4 = 1, `illegal` is 1, `operand` equals `reg_val` and `carry_out` equals `carry_in`, whatever the distance and shift code are.
- R10: `illegal` is 0 in immediate mode even when field bit 4 is 1. `src_sel` always equals field bits 3:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_field | input | 12 | Low twelve bits of the instruction word |
| imm_sel | input | 1 | 1 selects the rotated constant, 0 selects the shifted register value |
| reg_val | input | 32 | Value read from the register named by `src_sel` |
| carry_in | input | 1 | Current carry status flag |
| operand | output | 32 | Second ALU operand |
| carry_out | output | 1 | Shifter carry for flag updates |
| illegal | output | 1 | Register-specified shift distance requested |
| src_sel | output | 4 | Source register index taken from the field |

## Verification
The decode of field bit 4 and the normal shift decode act on the same field in the same evaluation. So an illegal request can carry a nonzero distance and any shift code, and the two paths compete for `operand` and `carry_out`. The bench applies bit-4 fields with every shift code and with both zero and nonzero distances. It expects the unshifted value and the incoming carry in every case, and it checks that bit 4 has no effect once immediate mode is selected. The expected results come from a bench model that moves the value one bit per step.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
  localparam int DATA_W = 32;
  localparam int IMM_W  = 8;
  localparam int ROT_W  = 4;
  localparam int AMT_W  = 5;
  localparam int SRC_W  = 4;
  localparam int FLD_W  = IMM_W + ROT_W;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } sh_kind_e;

  typedef struct packed {
    logic [IMM_W-1:0] imm8;
    logic [ROT_W-1:0] rot;
    logic [AMT_W-1:0] amt;
    sh_kind_e         kind;
    logic             by_reg;
    logic [SRC_W-1:0] src;
  } fld_dec_t;

  // Rotate right of a DATA_W word by an arbitrary distance.
  function automatic logic [DATA_W-1:0] rot_right(input logic [DATA_W-1:0] v,
                                                  input int unsigned n);
    int unsigned k;
    k = n % DATA_W;
    if (k == 0) return v;
    return (v >> k) | (v << (DATA_W - k));
  endfunction

  // Returns {carry, result} for a nonzero distance.
  function automatic logic [DATA_W:0] shift_apply(input logic [DATA_W-1:0] v,
                                                  input sh_kind_e kind,
                                                  input int unsigned n);
    logic [DATA_W:0] ext;
    logic [DATA_W-1:0] r;
    case (kind)
      SH_LSL: begin
        ext = {1'b0, v} << n;
        return {ext[DATA_W], ext[DATA_W-1:0]};
      end
      SH_LSR: begin
        ext = {v, 1'b0} >> n;
        return {ext[0], ext[DATA_W:1]};
      end
      SH_ASR: begin
        ext = $unsigned($signed({v, 1'b0}) >>> n);
        return {ext[0], ext[DATA_W:1]};
      end
      default: begin
        r = rot_right(v, n);
        return {r[DATA_W-1], r};
      end
    endcase
  endfunction
endpackage

// File: rtl/opsh_field_decode.sv
module opsh_field_decode
  import opsh_pkg::*;
(
  input  logic [FLD_W-1:0] fld,
  output fld_dec_t         dec
);
  always_comb begin
    dec.imm8   = fld[IMM_W-1:0];
    dec.rot    = fld[FLD_W-1:IMM_W];
    dec.amt    = fld[FLD_W-1:FLD_W-AMT_W];
    dec.kind   = sh_kind_e'(fld[6:5]);
    dec.by_reg = fld[4];
    dec.src    = fld[SRC_W-1:0];
  end
endmodule

// File: rtl/opsh_imm_rotator.sv
module opsh_imm_rotator
  import opsh_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int IW = IMM_W,
  parameter int RW = ROT_W
) (
  input  logic [IW-1:0] imm8,
  input  logic [RW-1:0] rot,
  input  logic          cin,
  output logic [W-1:0]  value,
  output logic          cout
);
  logic [W-1:0] stage [0:RW];

  assign stage[0] = {{(W-IW){1'b0}}, imm8};

  // Log-depth rotator: stage k rotates by 2^(k+1) when rot[k] is set.
  for (genvar k = 0; k < RW; k++) begin : g_stage
    localparam int STEP = (2 << k) % W;
    always_comb begin
      if (rot[k]) stage[k+1] = (stage[k] >> STEP) | (stage[k] << (W - STEP));
      else        stage[k+1] = stage[k];
    end
  end

  assign value = stage[RW];
  assign cout  = (rot == '0) ? cin : stage[RW][W-1];

  always_comb begin
    a_r1_bits_preserved: assert ($countones(value) == $countones(imm8));
    if (rot == '0) begin
      a_r1_no_rotate: assert (value == {{(W-IW){1'b0}}, imm8});
      a_r2_carry_kept: assert (cout == cin);
    end else begin
      a_r2_carry_top: assert (cout == value[W-1]);
    end
  end
endmodule

// File: rtl/opsh_reg_shifter.sv
module opsh_reg_shifter
  import opsh_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int AW = AMT_W
) (
  input  logic [W-1:0]  val,
  input  sh_kind_e      kind,
  input  logic [AW-1:0] amt,
  input  logic          cin,
  output logic [W-1:0]  value,
  output logic          cout
);
  logic [W:0] packed_res;
  logic       amt_zero;

  assign amt_zero   = (amt == '0);
  assign packed_res = shift_apply(val, kind, int'(amt));

  always_comb begin
    if (amt_zero) begin
      value = val;
      cout  = cin;
    end else begin
      value = packed_res[W-1:0];
      cout  = packed_res[W];
    end
  end

  always_comb begin
    if (amt_zero) begin
      a_r8_zero_dist: assert (value == val && cout == cin);
    end else begin
      case (kind)
        SH_LSL: a_r3_zero_low: assert (value[0] == 1'b0);
        SH_LSR: a_r4_zero_high: assert (value[W-1] == 1'b0);
        SH_ASR: a_r5_sign_fill: assert (value[W-1] == val[W-1]);
        default: a_r6_ror_bits: assert ($countones(value) == $countones(val));
      endcase
      if (kind != SH_LSL) begin
        a_r7_carry_right: assert (cout == val[amt - 1'b1]);
      end
    end
  end
endmodule

// File: rtl/operand_shifter_unit.sv
module operand_shifter_unit
  import opsh_pkg::*;
(
  input  logic [11:0] op_field,
  input  logic        imm_sel,
  input  logic [31:0] reg_val,
  input  logic        carry_in,
  output logic [31:0] operand,
  output logic        carry_out,
  output logic        illegal,
  output logic [3:0]  src_sel
);
  fld_dec_t          dec;
  logic [DATA_W-1:0] imm_value;
  logic              imm_carry;
  logic [DATA_W-1:0] sh_value;
  logic              sh_carry;
  logic              by_reg_req;

  opsh_field_decode u_dec (
    .fld (op_field),
    .dec (dec)
  );

  opsh_imm_rotator #(.W(DATA_W), .IW(IMM_W), .RW(ROT_W)) u_rot (
    .imm8  (dec.imm8),
    .rot   (dec.rot),
    .cin   (carry_in),
    .value (imm_value),
    .cout  (imm_carry)
  );

  opsh_reg_shifter #(.W(DATA_W), .AW(AMT_W)) u_sh (
    .val   (reg_val),
    .kind  (dec.kind),
    .amt   (dec.amt),
    .cin   (carry_in),
    .value (sh_value),
    .cout  (sh_carry)
  );

  assign by_reg_req = !imm_sel && dec.by_reg;
  assign illegal    = by_reg_req;
  assign src_sel    = dec.src;

  always_comb begin
    if (imm_sel) begin
      operand   = imm_value;
      carry_out = imm_carry;
    end else if (by_reg_req) begin
      operand   = reg_val;
      carry_out = carry_in;
    end else begin
      operand   = sh_value;
      carry_out = sh_carry;
    end
  end

  always_comb begin
    if (illegal) begin
      a_r9_passthrough: assert (operand == reg_val && carry_out == carry_in);
    end
    if (imm_sel) begin
      a_r10_no_illegal_imm: assert (!illegal);
      a_r1_imm_narrow: assert ($countones(operand) <= IMM_W);
    end
  end
endmodule

// File: tb/sim_operand_shifter_unit.sv
module sim_operand_shifter_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [11:0] op_field;
  logic        imm_sel;
  logic [31:0] reg_val;
  logic        carry_in;
  logic [31:0] operand;
  logic        carry_out;
  logic        illegal;
  logic [3:0]  src_sel;

  int checks = 0;
  int errors = 0;
  int wd = 0;

  operand_shifter_unit u0 (
    .op_field (op_field), .imm_sel (imm_sel), .reg_val (reg_val),
    .carry_in (carry_in), .operand (operand), .carry_out (carry_out),
    .illegal (illegal), .src_sel (src_sel)
  );

  // Step-by-step model, one bit per iteration.
  task automatic model(input logic [11:0] f, input logic im, input logic [31:0] v,
                       input logic ci, output logic [31:0] eo, output logic ec,
                       output logic ei);
    logic [31:0] x;
    logic c;
    int n;
    ei = 1'b0;
    if (im) begin
      x = {24'd0, f[7:0]};
      n = 2 * int'(f[11:8]);
      for (int i = 0; i < n; i++) x = {x[0], x[31:1]};
      eo = x;
      ec = (n == 0) ? ci : x[31];
    end else if (f[4]) begin
      eo = v; ec = ci; ei = 1'b1;
    end else begin
      x = v; c = ci; n = int'(f[11:7]);
      for (int i = 0; i < n; i++) begin
        case (f[6:5])
          2'b00: begin c = x[31]; x = {x[30:0], 1'b0}; end
          2'b01: begin c = x[0];  x = {1'b0, x[31:1]}; end
          2'b10: begin c = x[0];  x = {x[31], x[31:1]}; end
          default: begin c = x[0]; x = {x[0], x[31:1]}; end
        endcase
      end
      eo = x; ec = c;
    end
  endtask

  task automatic apply_check(input string req, input logic [11:0] f, input logic im,
                             input logic [31:0] v, input logic ci);
    logic [31:0] eo;
    logic ec, ei;
    @(posedge clk);
    op_field = f; imm_sel = im; reg_val = v; carry_in = ci;
    @(negedge clk);
    model(f, im, v, ci, eo, ec, ei);
    checks++;
    if (operand !== eo || carry_out !== ec || illegal !== ei || src_sel !== f[3:0]) begin
      errors++;
      $display("FAIL %s field=%h imm=%b val=%h cin=%b: got op=%h c=%b ill=%b src=%h exp op=%h c=%b ill=%b src=%h",
               req, f, im, v, ci, operand, carry_out, illegal, src_sel, eo, ec, ei, f[3:0]);
    end
  endtask

  function automatic logic [11:0] regf(input int amt, input int kind, input logic b4,
                                       input int src);
    return {amt[4:0], kind[1:0], b4, src[3:0]};
  endfunction

  task automatic t_reset_state();
    apply_check("R10 idle", 12'h000, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic t_immediate();
    apply_check("R1 rot0", 12'h0AB, 1'b1, 32'h0, 1'b1);
    apply_check("R1 rot4", 12'h4FF, 1'b1, 32'h0, 1'b0);
    apply_check("R1 rot15", 12'hF81, 1'b1, 32'h0, 1'b0);
    apply_check("R2 rot1", 12'h103, 1'b1, 32'h0, 1'b0);
    apply_check("R2 rot0 cin", 12'h080, 1'b1, 32'h0, 1'b1);
    for (int r = 0; r < 16; r++)
      apply_check("R1 R2 sweep", {r[3:0], 8'hC5}, 1'b1, 32'hFFFF_FFFF, r[0]);
  endtask

  task automatic t_register_kinds();
    logic [31:0] pats [0:3];
    pats[0] = 32'h8000_0001; pats[1] = 32'h7F3C_A5E1;
    pats[2] = 32'hF00D_0FF0; pats[3] = 32'h0000_0000;
    for (int p = 0; p < 4; p++)
      for (int a = 1; a < 32; a++) begin
        apply_check("R3 R7 lsl", regf(a, 0, 1'b0, p), 1'b0, pats[p], 1'b0);
        apply_check("R4 R7 lsr", regf(a, 1, 1'b0, p), 1'b0, pats[p], 1'b1);
        apply_check("R5 R7 asr", regf(a, 2, 1'b0, p), 1'b0, pats[p], 1'b0);
        apply_check("R6 R7 ror", regf(a, 3, 1'b0, p), 1'b0, pats[p], 1'b1);
      end
  endtask

  task automatic t_zero_distance();
    for (int k = 0; k < 4; k++) begin
      apply_check("R8 zero c1", regf(0, k, 1'b0, 5), 1'b0, 32'hDEAD_BEEF, 1'b1);
      apply_check("R8 zero c0", regf(0, k, 1'b0, 9), 1'b0, 32'h8000_0001, 1'b0);
    end
  endtask

  task automatic t_illegal();
    for (int k = 0; k < 4; k++) begin
      apply_check("R9 bit4 amt0", regf(0, k, 1'b1, 3), 1'b0, 32'h1234_5678, 1'b1);
      apply_check("R9 bit4 amt31", regf(31, k, 1'b1, 14), 1'b0, 32'h8765_4321, 1'b0);
    end
    apply_check("R10 imm bit4", 12'h3F0, 1'b1, 32'h0, 1'b0);
    apply_check("R10 imm bit4 rot0", 12'h01F, 1'b1, 32'hFFFF_FFFF, 1'b1);
  endtask

  initial begin
    op_field = '0; imm_sel = 1'b0; reg_val = '0; carry_in = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_immediate();
    t_register_kinds();
    t_zero_distance();
    t_illegal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (rst_n) wd <= wd + 1;
    if (wd > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles exp fewer than 20000", wd);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule